// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence of one read or write burst for a synchronous DRAM controller. A start strobe captures a start column, a burst-length code and an ordering choice. From the next cycle on, the block issues one column address per clock, together with a valid flag and a flag that marks the final beat. The controller that owns the programmed mode settings drives the length and ordering inputs. This block holds no mode state of its own.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside the aligned block that holds the start column. The order within that block is either sequential or interleaved. A full-page burst steps through every column, wraps from the top column to column 0, and continues until a stop request or a new start ends it. A new start may arrive on any cycle, including the final beat of a running burst, so bursts can follow each other with no idle cycle between them.

Top module: `sdr_col_gen`

## Requirements
- R1: While reset is held and after it is released with no start, `valid_o`, `last_o` and `col_o` are all 0. `col_o` is also 0 on every cycle where `valid_o` is 0.
- R2: A start sampled on a clock edge makes `valid_o` 1 and `col_o` equal to the sampled start column in the cycle after that edge.
- R3: Length codes on `blen_i` are 0, 1, 2 and 3, giving 1, 2, 4 and 8 beats. `last_o` is 1 on exactly the final beat, and `valid_o` returns to 0 on the next cycle unless a new start is sampled.
- R4: With `ilv_i` = 0 (sequential ordering), the low log2(BL) column bits count upward from the start value and wrap within the aligned block. All higher column bits stay at their start values.
- R5: With `ilv_i` = 1 (interleaved ordering), the low log2(BL) bits of beat n equal the low start bits XOR n. All higher bits stay at their start values.
- R6: Length codes 4 to 7 select full page. The column increments by one on each beat, wraps from 511 to 0, and continues without limit. `last_o` stays 0, and `ilv_i` has no effect in this mode.
- R7: `stop_i` sampled while a burst is active, with no start in the same cycle, makes `valid_o` 0 on the next cycle. This holds for every burst length.
- R8: A start sampled during an active burst abandons the old sequence, and the new start column appears on the next cycle. When start and stop are sampled together, the start wins.
- R9: A start sampled on the final beat of a burst makes the new burst's first beat follow with no idle cycle, so a column address is issued on every cycle.
- R10: `blen_i`, `ilv_i` and `start_col_i` are used only on the cycle a start is sampled. Changes to them during a burst leave the running sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst (also aborts a running one) |
| start_col_i | input | 9 | Start column captured with `start_i` |
| blen_i | input | 3 | Length code: 0..3 give 1,2,4,8 beats; 4..7 give full page |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | `col_o` carries a beat |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
A corrupted beat counter or captured start column shows up on `col_o` in the very next beat, either as a column outside the aligned block or as a wrong position within it. A wrong captured length shows up as `last_o` on the wrong beat, or as `valid_o` lasting one cycle too long or too short, at most eight cycles after the start. Stop and restart faults appear one cycle after the request, as `valid_o` staying high or the old sequence continuing. A full-page fault is caught where the count crosses from 511 to 0.

// File: rtl/sdr_col_gen_pkg.sv
package sdr_col_gen_pkg;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } col_order_e;

    // largest fixed length expressed as log2 (8 beats)
    localparam int unsigned MAX_FIX_LOG = 3;

endpackage

// File: rtl/sdr_bl_decode.sv
module sdr_bl_decode #(
    parameter int unsigned COL_W = 9,
    parameter int unsigned LEN_W = 3
) (
    input  logic [LEN_W-1:0] code_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o
);
    import sdr_col_gen_pkg::*;

    always_comb begin
        page_o = (int'(code_i) > int'(MAX_FIX_LOG));
    end

    // low-bit wrap mask: bit i is inside the burst block when i < log2(BL)
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        always_comb begin
            mask_o[i] = page_o | (int'(code_i) > i);
        end
    end

endmodule

// File: rtl/sdr_col_map.sv
module sdr_col_map #(
    parameter int unsigned COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    always_comb begin
        low_seq = (base_i + beat_i) & mask_i;
        low_ilv = (base_i ^ beat_i) & mask_i;
        col_o   = (base_i & ~mask_i) | (ilv_i ? low_ilv : low_seq);
    end

endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen #(
    parameter int unsigned COL_W = 9,
    parameter int unsigned LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LEN_W-1:0] blen_i,
    input  logic             ilv_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    import sdr_col_gen_pkg::*;

    typedef struct packed {
        logic             active;
        logic             last;
        logic [COL_W-1:0] col;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic             page;
        col_order_e       order;
    } gen_state_t;

    gen_state_t st_d;
    gen_state_t st_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] beat_nxt;
    logic [COL_W-1:0] col_nxt;
    logic [COL_W-1:0] cur_mask;
    logic             cur_page;

    sdr_bl_decode #(
        .COL_W (COL_W),
        .LEN_W (LEN_W)
    ) i_decode (
        .code_i (blen_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    always_comb begin
        beat_nxt = st_q.beat + 1'b1;
    end

    sdr_col_map #(
        .COL_W (COL_W)
    ) i_map (
        .base_i (st_q.base),
        .beat_i (beat_nxt),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.order == ORD_ILV),
        .col_o  (col_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = start_col_i;
            st_d.beat   = '0;
            st_d.mask   = dec_mask;
            st_d.page   = dec_page;
            st_d.order  = (ilv_i && !dec_page) ? ORD_ILV : ORD_SEQ;
            st_d.col    = start_col_i;
            st_d.last   = !dec_page && (dec_mask == '0);
        end else if (st_q.active && !stop_i && !st_q.last) begin
            st_d.beat   = beat_nxt;
            st_d.col    = col_nxt;
            st_d.last   = !st_q.page && (beat_nxt == st_q.mask);
        end else begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
            st_d.col    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_o    = st_q.col;
    assign valid_o  = st_q.active;
    assign last_o   = st_q.last;
    assign cur_mask = st_q.mask;
    assign cur_page = st_q.page;

endmodule

// File: rtl/sdr_col_gen_chk.sv
module sdr_col_gen_chk #(
    parameter int unsigned COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic [COL_W-1:0] cur_mask,
    input logic             cur_page
);

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));            // R2

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o);                                // R7

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);                                // R3

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);                                               // R3

    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cur_page) |-> !last_o);                                // R6

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(start_i))
            |-> (((col_o ^ $past(col_o)) & ~cur_mask) == '0));              // R4

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (col_o == '0 && !last_o));                            // R1

endmodule

bind sdr_col_gen sdr_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .cur_mask    (cur_mask),
    .cur_page    (cur_page)
);

// File: tb/test_sdr_col_gen.sv
module test_sdr_col_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       ilv_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        bit    v;
        bit    l;
        int    c;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // reference model state
    bit m_act = 0;
    int m_base = 0;
    int m_beat = 0;
    int m_len = 0;
    bit m_ilv = 0;

    always #5 clk = ~clk;

    sdr_col_gen i_sdr_col_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .blen_i      (blen_i),
        .ilv_i       (ilv_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    task automatic check(string tag, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic int ref_col();
        int low;
        if (m_len == 0) return (m_base + m_beat) % 512;
        if (m_ilv) low = (m_base % m_len) ^ m_beat;
        else       low = ((m_base % m_len) + m_beat) % m_len;
        return m_base - (m_base % m_len) + low;
    endfunction

    // one cycle of stimulus; pushes the output expected after the next edge
    task automatic cyc(bit st, int col, int code, bit ilv, bit sp, string tag);
        exp_t e;
        @(negedge clk);
        start_i     = st;
        start_col_i = col[8:0];
        blen_i      = code[2:0];
        ilv_i       = ilv;
        stop_i      = sp;
        if (st) begin
            m_act  = 1;
            m_base = col;
            m_beat = 0;
            m_len  = (code < 4) ? (1 << code) : 0;
            m_ilv  = (code < 4) ? ilv : 1'b0;
        end else if (m_act && (sp || (m_len != 0 && m_beat == m_len - 1))) begin
            m_act = 0;
        end else if (m_act) begin
            m_beat++;
        end
        e.v   = m_act;
        e.l   = m_act && m_len != 0 && m_beat == m_len - 1;
        e.c   = m_act ? ref_col() : 0;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, 37 * i + 5, i % 8, i[0], 0, tag);
    endtask

    // monitor: compares after each edge, away from it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.tag, " valid"}, int'(valid_o), int'(e.v));
                check({e.tag, " last"},  int'(last_o),  int'(e.l));
                check({e.tag, " col"},   int'(col_o),   e.c);
            end
        end
    end

    initial begin
        #50000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset valid", int'(valid_o), 0);
        check("R1 reset last",  int'(last_o),  0);
        check("R1 reset col",   int'(col_o),   0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1 idle");

        // R2 R4: sequential BL4 from a mid-block column
        cyc(1, 'hA6, 2, 0, 0, "R2 start");
        idle(5, "R4 seq BL4");

        // R3: every fixed length, sequential
        for (int k = 0; k < 4; k++) begin
            cyc(1, 'h15B, k, 0, 0, "R3 len start");
            idle(9, "R3 len run");
        end

        // R5: interleaved BL8 and BL4
        cyc(1, 'h1F5, 3, 1, 0, "R5 ilv8");
        idle(9, "R5 ilv8 run");
        cyc(1, 'h0C9, 2, 1, 0, "R5 ilv4");
        idle(5, "R5 ilv4 run");

        // R6 R7: full page across the top, then stop
        cyc(1, 'h1FC, 7, 0, 0, "R6 page");
        idle(8, "R6 page wrap");
        cyc(0, 0, 0, 0, 1, "R7 page stop");
        idle(2, "R7 after stop");

        // R6: interleave request ignored in full page
        cyc(1, 'h1FE, 4, 1, 0, "R6 page ilv");
        idle(4, "R6 page ilv run");
        cyc(0, 0, 0, 0, 1, "R7 stop");
        idle(1, "R7 idle");

        // R7: stop in the middle of BL8
        cyc(1, 'h040, 3, 0, 0, "R7 bl8");
        idle(2, "R7 bl8 run");
        cyc(0, 0, 0, 0, 1, "R7 bl8 stop");
        idle(3, "R7 bl8 after");

        // R8: restart mid burst, then start together with stop
        cyc(1, 'h100, 3, 0, 0, "R8 first");
        idle(2, "R8 first run");
        cyc(1, 'h033, 1, 1, 0, "R8 restart");
        cyc(1, 'h0F1, 2, 0, 1, "R8 start+stop");
        idle(5, "R8 run");

        // R9: back-to-back starts on the final beat
        cyc(1, 'h012, 1, 0, 0, "R9 a");
        cyc(0, 0, 0, 0, 0, "R9 a last");
        cyc(1, 'h1A3, 0, 0, 0, "R9 b");
        cyc(1, 'h077, 2, 1, 0, "R9 c");
        idle(5, "R9 c run");

        // R10: length, order and column inputs toggle during the burst (idle varies them)
        cyc(1, 'h0AD, 3, 0, 0, "R10 start");
        idle(10, "R10 run");

        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule